// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block is the digital sequencer of a successive approximation analog-to-digital converter. An external DAC turns the block's trial code into a voltage, and an external comparator reports whether that voltage lies above the held analog input. The block settles one result bit per clock, starting at the most significant bit and ending at the least significant bit. For an N-bit conversion this takes exactly N clock periods.

A one-cycle `start` pulse opens a conversion. `hold` is asserted for the whole conversion window, so the sample-and-hold stage keeps the input steady while the bits are decided. Each cycle the block keeps or drops the bit under test, according to the comparator result it samples, and raises the next lower bit as the new trial. When the last bit is settled, `done` pulses for one cycle and `result` takes the final code.

The width `N` is a parameter with a default of 6. A second parameter, `CMP_INV`, selects the comparator polarity.

Top module: `sar_ctrl`

## Requirements
- R1: A `start` accepted while idle sets `dac_code` to a 1 in bit N-1 with all other bits 0 in the cycle after the start edge, and raises `hold` in that same cycle.
- R2: When the comparator reports the trial at or below the input (`cmp_in`=0 with CMP_INV=0), the bit under test stays 1 and the next lower bit of `dac_code` is set to 1.
- R3: When the comparator reports the trial above the input (`cmp_in`=1 with CMP_INV=0), the bit under test is cleared to 0 and the next lower bit of `dac_code` is set to 1.
- R4: `cmp_in` is sampled once per bit, on the clock edge that follows the presentation of that bit's trial code on `dac_code`.
- R5: `hold` stays high for exactly N cycles after the start edge and falls on the edge where the LSB is decided.
- R6: `done` is high for exactly one cycle, beginning at the edge where the LSB is decided. In that cycle `result` carries the final code, which is the largest code whose DAC level does not exceed the input.
- R7: `result` stays unchanged from one completion to the next, whatever the comparator does in between.
- R8: A `start` that arrives during a conversion is ignored. The running conversion completes at its original time with its original result, and it produces a single `done`.
- R9: A synchronous `rst` returns the block to idle, with `hold`, `done`, `dac_code` and `result` all 0. A conversion cut off by reset never signals `done`.
- R10: With N=6, an input of 53.25 LSB (about 4.16 V on a 0 to 5 V span) gives `result` 110101.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to begin a conversion |
| cmp_in | input | 1 | Comparator output; with CMP_INV=0, 1 means the trial lies above the input |
| dac_code | output | N | Trial code driven to the DAC |
| hold | output | 1 | Sample-and-hold strobe, high during conversion |
| done | output | 1 | One-cycle completion pulse |
| result | output | N | Last completed conversion code |

## Verification
The intermediate trial codes are the hardest thing to observe: a wrong keep or drop decision on a middle bit can still lead to a plausible final code. The bench therefore models the DAC and comparator as an arithmetic comparison against an input held at a sixteenth-of-an-LSB resolution. It sweeps every such input level and checks the trial code after each edge against the prefix of the expected result. Both a late start and a reset that cut into a running conversion are injected at chosen bit positions, so that the block is in the middle of the bit sequence when they arrive.

// File: rtl/sar_pkg.sv
package sar_pkg;
   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_CONV = 1'b1
   } sar_state_e;
endpackage

// File: rtl/sar_seq.sv
module sar_seq
   import sar_pkg::*;
#(
   parameter int N = 6
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         start,
   output logic         accept,
   output logic         conv,
   output logic         last,
   output logic [N-1:0] ptr
);
   localparam logic [N-1:0] TOP_ONE = {1'b1, {(N-1){1'b0}}};

   sar_state_e state_q;

   assign conv   = (state_q == ST_CONV);
   assign accept = start & ~conv;
   assign last   = conv & ptr[0];

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         ptr     <= '0;
      end else if (accept) begin
         state_q <= ST_CONV;
         ptr     <= TOP_ONE;
      end else if (conv) begin
         ptr <= ptr >> 1;
         if (ptr[0]) state_q <= ST_IDLE;
      end
   end
endmodule

// File: rtl/sar_trial.sv
module sar_trial #(
   parameter int N = 6
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         accept,
   input  logic         conv,
   input  logic [N-1:0] ptr,
   input  logic         above,
   output logic [N-1:0] code,
   output logic [N-1:0] code_nx
);
   for (genvar i = 0; i < N; i++) begin : g_bit
      if (i == N - 1) begin : g_top
         always_comb begin
            code_nx[i] = code[i];
            if (accept)                code_nx[i] = 1'b1;
            else if (conv && ptr[i])   code_nx[i] = ~above;
         end
      end else begin : g_low
         always_comb begin
            code_nx[i] = code[i];
            if (accept)                 code_nx[i] = 1'b0;
            else if (conv && ptr[i])    code_nx[i] = ~above;
            else if (conv && ptr[i+1])  code_nx[i] = 1'b1;
         end
      end

      always_ff @(posedge clk) begin
         if (rst) code[i] <= 1'b0;
         else     code[i] <= code_nx[i];
      end
   end
endmodule

// File: rtl/sar_out.sv
module sar_out #(
   parameter int N = 6
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         last,
   input  logic [N-1:0] final_code,
   output logic         done,
   output logic [N-1:0] result
);
   always_ff @(posedge clk) begin
      if (rst) begin
         done   <= 1'b0;
         result <= '0;
      end else begin
         done <= last;
         if (last) result <= final_code;
      end
   end
endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl #(
   parameter int N       = 6,
   parameter bit CMP_INV = 1'b0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         start,
   input  logic         cmp_in,
   output logic [N-1:0] dac_code,
   output logic         hold,
   output logic         done,
   output logic [N-1:0] result
);
   if (N < 2 || N > 32) begin : g_bad_width
      $error("sar_ctrl: N must lie in 2..32");
   end

   logic         accept;
   logic         conv;
   logic         last;
   logic         above;
   logic [N-1:0] ptr;
   logic [N-1:0] code_nx;

   if (CMP_INV) begin : g_cmp_low_active
      assign above = ~cmp_in;
   end else begin : g_cmp_high_active
      assign above = cmp_in;
   end

   sar_seq #(.N(N)) u_seq (
      .clk    (clk),
      .rst    (rst),
      .start  (start),
      .accept (accept),
      .conv   (conv),
      .last   (last),
      .ptr    (ptr)
   );

   sar_trial #(.N(N)) u_trial (
      .clk     (clk),
      .rst     (rst),
      .accept  (accept),
      .conv    (conv),
      .ptr     (ptr),
      .above   (above),
      .code    (dac_code),
      .code_nx (code_nx)
   );

   sar_out #(.N(N)) u_out (
      .clk        (clk),
      .rst        (rst),
      .last       (last),
      .final_code (code_nx),
      .done       (done),
      .result     (result)
   );

   assign hold = conv;
endmodule

// File: rtl/sar_ctrl_chk.sv
module sar_ctrl_chk #(
   parameter int N = 6
) (
   input logic         clk,
   input logic         rst,
   input logic [N-1:0] dac_code,
   input logic         hold,
   input logic         done,
   input logic [N-1:0] result
);
   localparam logic [N-1:0] TOP_ONE = {1'b1, {(N-1){1'b0}}};

   int unsigned hold_cnt;

   always_ff @(posedge clk) begin
      if (rst || !hold) hold_cnt <= 0;
      else              hold_cnt <= hold_cnt + 1;
   end

   a_r1_msb_first: assert property (@(posedge clk) disable iff (rst)
      $rose(hold) |-> dac_code == TOP_ONE);

   a_r5_hold_window: assert property (@(posedge clk) disable iff (rst)
      ($fell(hold) && !$past(rst)) |-> hold_cnt == N);

   a_r6_done_at_end: assert property (@(posedge clk) disable iff (rst)
      ($fell(hold) && !$past(rst)) |-> done);

   a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   a_r7_result_kept: assert property (@(posedge clk) disable iff (rst)
      (!done && !$past(rst)) |-> $stable(result));

   a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
      (!hold && !$past(hold)) |-> !done);
endmodule

bind sar_ctrl sar_ctrl_chk #(.N(N)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .dac_code (dac_code),
   .hold     (hold),
   .done     (done),
   .result   (result)
);

// File: tb/sim_sar_ctrl.sv
`timescale 1ns/1ps
module sim_sar_ctrl;
   localparam int N    = 6;
   localparam int SUB  = 16;
   localparam int MAXC = (1 << N) - 1;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         start = 1'b0;
   logic         cmp_in;
   logic [N-1:0] dac_code;
   logic         hold;
   logic         done;
   logic [N-1:0] result;
   int           vin_q = 0;
   int           n_chk = 0;
   int           n_bad = 0;
   bit           finished = 1'b0;

   always #10 clk = ~clk;

   assign cmp_in = (int'(dac_code) * SUB > vin_q);

   sar_ctrl #(.N(N), .CMP_INV(1'b0)) u0 (
      .clk(clk), .rst(rst), .start(start), .cmp_in(cmp_in),
      .dac_code(dac_code), .hold(hold), .done(done), .result(result)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // inject: 0 none, 1 late start at step 2, 2 reset at step 3
   task automatic run_conv(input int vq, input int inject);
      int expc;
      expc = vq / SUB;
      if (expc > MAXC) expc = MAXC;
      @(negedge clk);
      vin_q = vq;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(dac_code == (1 << (N-1)), "R1 msb trial", dac_code, 1 << (N-1));
      chk(hold == 1'b1, "R1 hold rises", hold, 1);
      for (int j = 1; j < N; j++) begin
         int pre;
         if (inject == 1 && j == 2) start = 1'b1;
         if (inject == 2 && j == 3) rst = 1'b1;
         @(negedge clk);
         start = 1'b0;
         if (inject == 2 && j == 3) begin
            rst = 1'b0;
            chk(hold == 1'b0 && done == 1'b0, "R9 reset mid conversion", {hold, done}, 0);
            chk(dac_code == 0 && result == 0, "R9 reset clears codes", dac_code, 0);
            for (int k = 0; k < N + 2; k++) begin
               @(negedge clk);
               chk(done == 1'b0 && hold == 1'b0, "R9 no done after reset", done, 0);
            end
            return;
         end
         pre = ((expc >> (N - j)) << (N - j)) | (1 << (N - 1 - j));
         if (((expc >> (N - j)) & 1) != 0)
            chk(dac_code == pre, "R2 bit kept R4", dac_code, pre);
         else
            chk(dac_code == pre, "R3 bit dropped R4", dac_code, pre);
         chk(hold == 1'b1 && done == 1'b0, "R5 hold during window", {hold, done}, 2);
      end
      @(negedge clk);
      chk(done == 1'b1, "R6 done after N cycles", done, 1);
      chk(hold == 1'b0, "R5 hold falls", hold, 0);
      if (inject == 1)
         chk(result == expc, "R8 late start ignored", result, expc);
      else
         chk(result == expc, "R6 final code", result, expc);
      @(negedge clk);
      chk(done == 1'b0, "R6 done one cycle", done, 0);
      if (inject == 1)
         chk(hold == 1'b0, "R8 no second conversion", hold, 0);
      vin_q = MAXC * SUB - vq;
      repeat (3) @(negedge clk);
      chk(result == expc && done == 1'b0, "R7 result held", result, expc);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(hold == 0 && done == 0, "R9 reset state ctl", {hold, done}, 0);
      chk(dac_code == 0 && result == 0, "R9 reset state codes", dac_code, 0);
      rst = 1'b0;
      @(negedge clk);
      run_conv(852, 0);
      chk(result == 6'b110101, "R10 example code", result, 53);
      for (int v = 0; v < (MAXC + 1) * SUB; v++) run_conv(v, 0);
      run_conv(300, 1);
      run_conv(999, 1);
      run_conv(500, 2);
      run_conv(700, 0);
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule